// File: doc/BRIEF.md
# HDLC Packet-over-SONET Byte Transmitter

This block turns packets taken from a transmit FIFO into the continuous HDLC byte stream that fills a SONET payload. The payload generator raises `out_en` once for every payload byte it wants. For each such request the block chooses exactly one byte, and that byte appears on `out_data` on the following cycle. Between packets the block sends flag bytes. A packet is sent between flags, with every flag or escape value inside it escaped. A 16-bit or 32-bit frame check sequence can follow the packet. The block can also scramble the stream with a self-synchronous x^43+1 scrambler, placed either in front of the HDLC stage or behind it.

On the FIFO side each byte arrives with a valid flag and three markers: start of packet, end of packet and error. A byte is taken in every cycle in which `in_ready` and `in_valid` are both high. The FIFO may run dry in the middle of a packet, so that no byte is valid when the payload needs one. It may also mark a byte as bad. In both cases the block closes the frame with an abort sequence and goes back to sending fill.

The control is a five-state machine. **IDLE** sends flags. It goes to **DATA** on a payload request while a start-of-packet byte is waiting. **DATA** sends packet bytes. From DATA the machine goes to **ESC** when a byte needs escaping, to **FCS** or back to **IDLE** at end of packet, and to **ABORT** on underrun or error. **ESC** sends the escaped second byte and then returns to the state held in a return register: DATA, FCS or IDLE. **FCS** sends the check bytes and goes to **ESC** when one of them needs escaping; after the last one it goes to **IDLE**. **ABORT** sends the closing flag of the abort sequence and goes to **IDLE**.

Top module: `pos_hdlc_tx`

## Requirements
- R1: After reset, `out_data` is 0x7E and `in_ready` is low while no byte is offered.
- R2: Every `out_en` cycle produces exactly one byte, which appears on `out_data` on the next cycle. `out_data` holds its value after a cycle without `out_en`. With no frame in progress, each byte produced is the flag 0x7E.
- R3: A frame opens when a payload request meets a waiting start-of-packet byte; the flag sent in that cycle is the opening flag. Packet bytes follow in order. A byte equal to 0x7E or 0x7D is sent as 0x7D followed by the byte XOR 0x20.
- R4: With the FCS enabled and 16-bit size selected, the end-of-packet byte is followed by the ones complement of CRC-CCITT. This CRC is bit-reflected, with polynomial x^16+x^12+x^5+1, and is preset to all ones. The check bytes are sent low byte first and are escaped like data.
- R5: With the FCS enabled and 32-bit size selected, the check is the ones complement of the reflected CRC-32 (polynomial 0x04C11DB7), preset to all ones. It is sent as four bytes, low byte first, and escaped like data.
- R6: With the FCS disabled, the byte after the last packet byte (or after its escape) is a flag.
- R7: If no valid byte is offered on an `out_en` cycle in the middle of a packet, nothing is taken. The block sends 0x7D and then 0x7E, and returns to fill.
- R8: A valid byte marked with the error flag inside a packet is taken but not sent. The block sends the abort sequence 0x7D 0x7E instead.
- R9: While idle, a valid byte without start of packet is taken and discarded. It has no effect on the output.
- R10: In post-HDLC scrambling mode, every byte sent is scrambled with x^43+1, MSB first. Each output bit is the input bit XOR the output bit 43 bits earlier, and the scrambler history is zero after reset.
- R11: In pre-HDLC scrambling mode, only accepted good packet bytes pass through the same scrambler, before escaping and FCS computation. Flags, escapes and check bytes are sent unscrambled.
- R12: `in_ready` is high inside a frame only on an `out_en` cycle in DATA. At most one byte is taken per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fcs_en | input | 1 | Append a frame check sequence |
| cfg_fcs32 | input | 1 | 1: 32-bit FCS, 0: 16-bit FCS |
| cfg_scr_en | input | 1 | Enable the x^43+1 scrambler |
| cfg_scr_pre | input | 1 | 1: scramble before HDLC, 0: after |
| in_valid | input | 1 | FIFO byte valid |
| in_data | input | 8 | FIFO byte |
| in_sop | input | 1 | Byte starts a packet |
| in_eop | input | 1 | Byte ends a packet |
| in_err | input | 1 | Byte marked bad by the FIFO |
| in_ready | output | 1 | Byte taken this cycle |
| out_en | input | 1 | Payload generator requests a byte |
| out_data | output | 8 | Output byte, one cycle after the request |

## Verification
The bench targets the following corner cases.

- **Data bytes equal to the flag or escape value, and check bytes that happen to be escaped.** A design that skips the escape would let the receiver close the frame early. A design that escapes only data would corrupt the check.
- **An underrun that lands on a request cycle.** A design that stalls there, instead of aborting, would leak a partial frame. Leftover packet bytes arriving afterwards must be thrown away, not opened as a new frame.
- **Both scrambler placements.** A pre-HDLC scrambler that also advanced on flags, or a post-HDLC scrambler that skipped them, would drift out of step with the descrambler.
- **Payload request patterns with gaps.** A design that produced bytes on idle cycles, or took FIFO bytes without a request, would drop or repeat bytes.

// File: rtl/pos_tx_pkg.sv
package pos_tx_pkg;

    localparam logic [7:0] HDLC_FLAG = 8'h7E;
    localparam logic [7:0] HDLC_ESC  = 8'h7D;
    localparam logic [7:0] HDLC_FLIP = 8'h20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_ESC,
        ST_FCS,
        ST_ABORT
    } tx_st_e;

    function automatic logic needs_esc(input logic [7:0] b);
        return (b == HDLC_FLAG) || (b == HDLC_ESC);
    endfunction

endpackage

// File: rtl/pos_tx_fcs.sv
module pos_tx_fcs #(
    parameter logic [15:0] POLY16 = 16'h8408,
    parameter logic [31:0] POLY32 = 32'hEDB88320
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic        sel32,
    input  logic [7:0]  din,
    output logic [31:0] fcs
);
    logic [31:0] crc_q;
    logic [31:0] nxt32;
    logic [15:0] nxt16;

    always_comb begin
        nxt32 = crc_q;
        nxt16 = crc_q[15:0];
        for (int i = 0; i < 8; i++) begin
            nxt32 = (nxt32[0] ^ din[i]) ? ((nxt32 >> 1) ^ POLY32) : (nxt32 >> 1);
            nxt16 = (nxt16[0] ^ din[i]) ? ((nxt16 >> 1) ^ POLY16) : (nxt16 >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      crc_q <= '1;
        else if (clr)    crc_q <= '1;
        else if (en)     crc_q <= sel32 ? nxt32 : {16'hFFFF, nxt16};
    end

    assign fcs = ~crc_q;

endmodule

// File: rtl/pos_tx_scr.sv
module pos_tx_scr #(
    parameter int TAP = 43
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       sel_post,
    input  logic [7:0] din_pre,
    input  logic [7:0] din_post,
    output logic [7:0] dout_pre,
    output logic [7:0] dout_post
);
    logic [TAP-1:0] hist_q;
    logic [TAP-1:0] h_pre;
    logic [TAP-1:0] h_post;

    always_comb begin
        h_pre = hist_q;
        for (int i = 7; i >= 0; i--) begin
            dout_pre[i] = din_pre[i] ^ h_pre[TAP-1];
            h_pre = {h_pre[TAP-2:0], dout_pre[i]};
        end
    end

    always_comb begin
        h_post = hist_q;
        for (int i = 7; i >= 0; i--) begin
            dout_post[i] = din_post[i] ^ h_post[TAP-1];
            h_post = {h_post[TAP-2:0], dout_post[i]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hist_q <= '0;
        else if (adv) hist_q <= sel_post ? h_post : h_pre;
    end

endmodule

// File: rtl/pos_hdlc_tx.sv
module pos_hdlc_tx
    import pos_tx_pkg::*;
#(
    parameter int SCR_TAP = 43
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_fcs_en,
    input  logic       cfg_fcs32,
    input  logic       cfg_scr_en,
    input  logic       cfg_scr_pre,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_sop,
    input  logic       in_eop,
    input  logic       in_err,
    output logic       in_ready,
    input  logic       out_en,
    output logic [7:0] out_data
);
    localparam int FCS16_BYTES = 2;
    localparam int FCS32_BYTES = 4;
    localparam int IDX_W       = $clog2(FCS32_BYTES);

    tx_st_e          st, st_nxt, ret_q, ret_d;
    logic [7:0]      esc_q, esc_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [7:0]      emit, data_b, fcs_b, out_q;
    logic [7:0]      scr_pre_out, scr_post_out;
    logic [31:0]     fcs_val, fcs_sh;
    logic            take_good, crc_clr, fcs_last, scr_post, scr_pre, scr_adv;
    tx_st_e          tgt;

    assign scr_post = cfg_scr_en && !cfg_scr_pre;
    assign scr_pre  = cfg_scr_en &&  cfg_scr_pre;
    assign data_b   = scr_pre ? scr_pre_out : in_data;
    assign fcs_sh   = fcs_val >> (8 * idx_q);
    assign fcs_b    = fcs_sh[7:0];
    assign fcs_last = cfg_fcs32 ? (idx_q == IDX_W'(FCS32_BYTES - 1))
                                : (idx_q == IDX_W'(FCS16_BYTES - 1));
    assign scr_adv  = scr_post ? out_en : (scr_pre && take_good);

    pos_tx_fcs u_fcs (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (take_good),
        .sel32 (cfg_fcs32),
        .din   (data_b),
        .fcs   (fcs_val)
    );

    pos_tx_scr #(.TAP(SCR_TAP)) u_scr (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (scr_adv),
        .sel_post  (scr_post),
        .din_pre   (in_data),
        .din_post  (emit),
        .dout_pre  (scr_pre_out),
        .dout_post (scr_post_out)
    );

    // State and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            ret_q <= ST_IDLE;
            esc_q <= '0;
            idx_q <= '0;
        end else begin
            st    <= st_nxt;
            ret_q <= ret_d;
            esc_q <= esc_d;
            idx_q <= idx_d;
        end
    end

    // Next state, byte choice and FIFO handshake
    always_comb begin
        st_nxt    = st;
        ret_d     = ret_q;
        esc_d     = esc_q;
        idx_d     = idx_q;
        emit      = HDLC_FLAG;
        in_ready  = 1'b0;
        take_good = 1'b0;
        crc_clr   = 1'b0;
        tgt       = ST_IDLE;
        unique case (st)
            ST_IDLE: begin
                crc_clr  = 1'b1;
                idx_d    = '0;
                in_ready = in_valid && !in_sop;
                if (out_en && in_valid && in_sop) st_nxt = ST_DATA;
            end
            ST_DATA: begin
                if (out_en) begin
                    if (!in_valid) begin
                        emit   = HDLC_ESC;
                        st_nxt = ST_ABORT;
                    end else begin
                        in_ready = 1'b1;
                        if (in_err) begin
                            emit   = HDLC_ESC;
                            st_nxt = ST_ABORT;
                        end else begin
                            take_good = 1'b1;
                            tgt = in_eop ? (cfg_fcs_en ? ST_FCS : ST_IDLE) : ST_DATA;
                            if (needs_esc(data_b)) begin
                                emit   = HDLC_ESC;
                                esc_d  = data_b ^ HDLC_FLIP;
                                ret_d  = tgt;
                                st_nxt = ST_ESC;
                            end else begin
                                emit   = data_b;
                                st_nxt = tgt;
                            end
                        end
                    end
                end
            end
            ST_ESC: begin
                if (out_en) begin
                    emit   = esc_q;
                    st_nxt = ret_q;
                end
            end
            ST_FCS: begin
                if (out_en) begin
                    idx_d = idx_q + 1'b1;
                    tgt   = fcs_last ? ST_IDLE : ST_FCS;
                    if (needs_esc(fcs_b)) begin
                        emit   = HDLC_ESC;
                        esc_d  = fcs_b ^ HDLC_FLIP;
                        ret_d  = tgt;
                        st_nxt = ST_ESC;
                    end else begin
                        emit   = fcs_b;
                        st_nxt = tgt;
                    end
                end
            end
            ST_ABORT: begin
                if (out_en) st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // Output byte register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      out_q <= HDLC_FLAG;
        else if (out_en) out_q <= scr_post ? scr_post_out : emit;
    end

    assign out_data = out_q;

endmodule

// File: rtl/pos_hdlc_tx_chk.sv
module pos_hdlc_tx_chk
    import pos_tx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       out_en,
    input logic       in_valid,
    input logic       in_err,
    input logic       in_ready,
    input logic       cfg_scr_en,
    input logic       cfg_fcs32,
    input logic [7:0] out_data,
    input tx_st_e     st,
    input logic [1:0] idx
);
    // R2
    idle_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && out_en && !cfg_scr_en) |=> (out_data == HDLC_FLAG));

    // R2
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> $stable(out_data));

    // R7
    underrun_esc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && out_en && !in_valid && !cfg_scr_en)
            |=> (out_data == HDLC_ESC && st == ST_ABORT));

    // R7
    abort_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ABORT && out_en) |=> (st == ST_IDLE));

    // R8
    err_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && out_en && in_valid && in_err) |-> in_ready);

    // R8
    err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && out_en && in_valid && in_err) |=> (st == ST_ABORT));

    // R12
    ready_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && st != ST_IDLE) |-> (out_en && st == ST_DATA));

    // R4 R5
    fcs_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FCS) |-> (idx < (cfg_fcs32 ? 2'd3 : 2'd1) || idx == (cfg_fcs32 ? 2'd3 : 2'd1)));

endmodule

bind pos_hdlc_tx pos_hdlc_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_en     (out_en),
    .in_valid   (in_valid),
    .in_err     (in_err),
    .in_ready   (in_ready),
    .cfg_scr_en (cfg_scr_en),
    .cfg_fcs32  (cfg_fcs32),
    .out_data   (out_data),
    .st         (st),
    .idx        (idx_q)
);

// File: tb/pos_hdlc_tx_tb.sv
module pos_hdlc_tx_tb;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       cfg_fcs_en = 0, cfg_fcs32 = 0, cfg_scr_en = 0, cfg_scr_pre = 0;
    logic       in_valid = 0, in_sop = 0, in_eop = 0, in_err = 0, out_en = 0;
    logic [7:0] in_data = 0;
    logic       in_ready;
    logic [7:0] out_data;

    pos_hdlc_tx u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_fcs_en(cfg_fcs_en), .cfg_fcs32(cfg_fcs32),
        .cfg_scr_en(cfg_scr_en), .cfg_scr_pre(cfg_scr_pre),
        .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop),
        .in_eop(in_eop), .in_err(in_err), .in_ready(in_ready),
        .out_en(out_en), .out_data(out_data)
    );

    typedef struct { bit v; bit [7:0] d; bit s; bit e; bit x; } item_t;

    int        n_tests = 0, n_fail = 0, wd = 0, cyc = 0;
    item_t     stim[$];
    bit [7:0]  pend[$];
    bit        hist[$];
    bit        in_pkt;
    bit [31:0] mcrc;
    bit        last_oen;
    bit [7:0]  last_exp;

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_fail++; n_tests++;
            $display("FAIL R12 watchdog expired: actual=%0d cycles expected<150000", wd);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    function automatic bit [7:0] m_scr(input bit [7:0] d);
        bit [7:0] r;
        for (int i = 7; i >= 0; i--) begin
            r[i] = d[i] ^ hist.pop_front();
            hist.push_back(r[i]);
        end
        return r;
    endfunction

    function automatic void m_crc(input bit [7:0] b);
        bit [15:0] c = mcrc[15:0];
        for (int i = 0; i < 8; i++) begin
            if (cfg_fcs32) begin
                bit fb = mcrc[0] ^ b[i];
                mcrc = mcrc >> 1;
                if (fb) mcrc = mcrc ^ 32'hEDB88320;
            end else begin
                bit fb = c[0] ^ b[i];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        end
        if (!cfg_fcs32) mcrc = {16'h0, c};
    endfunction

    function automatic void m_stuff(input bit [7:0] b);
        if (b == 8'h7E || b == 8'h7D) begin
            pend.push_back(8'h7D);
            pend.push_back(b ^ 8'h20);
        end else pend.push_back(b);
    endfunction

    task automatic model_step(input item_t it, input bit oen,
                              output bit rdy, output bit [7:0] b);
        rdy = 0;
        b = 8'h00;
        if (pend.size() == 0 && !in_pkt && it.v && !it.s) rdy = 1;
        if (oen) begin
            if (pend.size() > 0) b = pend.pop_front();
            else if (!in_pkt) begin
                b = 8'h7E;
                if (it.v && it.s) begin in_pkt = 1; mcrc = '1; end
            end else if (!it.v || it.x) begin
                rdy = it.v;
                b = 8'h7D;
                pend.push_back(8'h7E);
                in_pkt = 0;
            end else begin
                bit [7:0] x = it.d;
                rdy = 1;
                if (cfg_scr_en && cfg_scr_pre) x = m_scr(x);
                m_crc(x);
                m_stuff(x);
                if (it.e) begin
                    in_pkt = 0;
                    if (cfg_fcs_en) begin
                        bit [31:0] f = ~mcrc;
                        for (int k = 0; k < (cfg_fcs32 ? 4 : 2); k++) m_stuff(f[8*k +: 8]);
                    end
                end
                b = pend.pop_front();
            end
            if (cfg_scr_en && !cfg_scr_pre) b = m_scr(b);
        end
    endtask

    task automatic add_pkt(input bit [7:0] bytes[$]);
        foreach (bytes[i]) begin
            item_t it;
            it.v = 1; it.d = bytes[i]; it.s = (i == 0);
            it.e = (i == bytes.size() - 1); it.x = 0;
            stim.push_back(it);
        end
    endtask

    task automatic add_raw(input bit v, input bit [7:0] d, input bit s, input bit e, input bit x);
        item_t it;
        it.v = v; it.d = d; it.s = s; it.e = e; it.x = x;
        stim.push_back(it);
    endtask

    task automatic run_case(input string tag, input bit fe, input bit f32,
                            input bit se, input bit sp, input int pat);
        int tail = 0, guard = 0;
        rst_n = 0;
        in_valid = 0; in_sop = 0; in_eop = 0; in_err = 0; out_en = 0; in_data = 0;
        cfg_fcs_en = fe; cfg_fcs32 = f32; cfg_scr_en = se; cfg_scr_pre = sp;
        repeat (3) @(negedge clk);
        rst_n = 1;
        pend.delete(); hist.delete();
        for (int i = 0; i < 43; i++) hist.push_back(1'b0);
        in_pkt = 0; mcrc = '1; last_oen = 0; last_exp = 8'h7E;
        #1;
        // R1 reset state
        chk(out_data == 8'h7E, "R1", "reset out_data", out_data, 8'h7E);
        chk(in_ready == 1'b0, "R1", "reset in_ready", in_ready, 0);
        while (tail < 6 && guard < 4000) begin
            item_t it;
            bit oen, rdy;
            bit [7:0] b;
            @(negedge clk);
            if (last_oen) chk(out_data == last_exp, tag, "out_data", out_data, last_exp);
            else          chk(out_data == last_exp, "R2", "out_data hold", out_data, last_exp);
            case (pat)
                0:       oen = 1;
                1:       oen = (cyc % 3) != 2;
                default: oen = (cyc % 2) == 0;
            endcase
            if (stim.size() > 0) it = stim[0];
            else begin it.v = 0; it.d = 0; it.s = 0; it.e = 0; it.x = 0; end
            in_valid = it.v; in_data = it.d; in_sop = it.s; in_eop = it.e; in_err = it.x;
            out_en = oen;
            #1;
            model_step(it, oen, rdy, b);
            chk(in_ready == rdy, "R12", "in_ready", in_ready, rdy);
            if (stim.size() > 0 && (!stim[0].v || rdy)) void'(stim.pop_front());
            if (oen) last_exp = b;
            last_oen = oen;
            if (stim.size() == 0 && pend.size() == 0 && !in_pkt) tail++;
            guard++; cyc++;
        end
        in_valid = 0; out_en = 0;
    endtask

    initial begin
        // R3 R6: escaping without FCS, back-to-back packets
        add_pkt('{8'h11, 8'h7E, 8'h22, 8'h7D, 8'h33});
        add_pkt('{8'h7D});
        add_pkt('{8'h44, 8'h55});
        run_case("R3 R6", 0, 0, 0, 0, 0);

        // R4: 16-bit FCS
        add_pkt('{8'h01, 8'h02, 8'h03, 8'h7E});
        add_pkt('{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39});
        add_pkt('{8'h7D, 8'h7E});
        run_case("R4", 1, 0, 0, 0, 0);

        // R5 R2: 32-bit FCS with gaps in payload requests
        add_pkt('{8'hFF, 8'h00, 8'h7E, 8'hA5});
        add_pkt('{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39});
        run_case("R5 R2", 1, 1, 0, 0, 1);

        // R7 R9: underrun mid-packet, leftovers discarded, then a clean packet
        add_raw(1, 8'hA1, 1, 0, 0);
        add_raw(1, 8'hA2, 0, 0, 0);
        add_raw(0, 8'h00, 0, 0, 0);
        add_raw(1, 8'hA3, 0, 0, 0);
        add_raw(1, 8'h7E, 0, 0, 0);
        add_raw(1, 8'hA4, 0, 1, 0);
        add_pkt('{8'hB1, 8'hB2});
        run_case("R7 R9", 1, 0, 0, 0, 0);

        // R8: error-marked byte aborts, rest discarded
        add_raw(1, 8'hC1, 1, 0, 0);
        add_raw(1, 8'hC2, 0, 0, 1);
        add_raw(1, 8'hC3, 0, 1, 0);
        add_pkt('{8'hD1, 8'h7D, 8'hD2});
        run_case("R8", 1, 1, 0, 0, 2);

        // R10: post-HDLC scrambling
        add_pkt('{8'h7E, 8'h12, 8'h7D, 8'h34, 8'h56});
        add_pkt('{8'h00, 8'h00, 8'h00});
        run_case("R10", 1, 1, 1, 0, 0);

        // R11: pre-HDLC scrambling
        add_pkt('{8'h7E, 8'h12, 8'h7D, 8'h34, 8'h56, 8'h78});
        add_pkt('{8'h7E, 8'h7E, 8'h7E});
        run_case("R11", 1, 0, 1, 1, 1);

        // R12 R9: strays before a packet, sparse requests
        add_raw(1, 8'h99, 0, 0, 0);
        add_raw(1, 8'h98, 0, 1, 0);
        add_pkt('{8'hE1, 8'h7E, 8'hE2});
        add_pkt('{8'hF1});
        run_case("R12 R9", 0, 0, 0, 0, 2);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule